// File: doc/BRIEF.md
# Flag-and-Pull Tile Message Controller

This block sits in each tile of a multi-tile fabric and moves fixed-length messages between a producer on one tile and a consumer on another. The producer never pushes data across the network. It keeps the payload in a slot of its own message store, one slot for each destination. It then sends a single flag request to the destination tile and is free again. The consumer side of the destination tile finds the flag in its semaphore bank, pulls the payload with a read request, streams the received words to its local sink, and sends a completion request back. The completion clears the producer's pending bit for that pair. Only one message can be in flight for each ordered producer-consumer pair, so data only moves when the consumer is ready to take it.

Tiles connect through two ideal channels. The request channel carries a 2-bit kind code and a destination id, and has one input lane for each source tile. The response channel carries payload words, also with one input lane for each source. There are three state machines. The producer has states P_IDLE and P_POST: P_IDLE goes to P_POST when a send is accepted, and P_POST goes back to P_IDLE when the flag is granted. The consumer has states C_IDLE, C_ASK, C_RECV and C_DONE: C_IDLE goes to C_ASK when some flag is set, C_ASK goes to C_RECV when the read is issued, C_RECV goes to C_DONE on the last word, and C_DONE goes back to C_IDLE when the completion is sent. The responder has states R_IDLE and R_SEND: R_IDLE goes to R_SEND when a read is wanted, and R_SEND goes back to R_IDLE after the final word.

Top module: `msg_tile`

## Requirements
- R1: After reset, every pending bit and every semaphore flag is clear. `snd_rdy` is 1, `done_err` is 0, and `snd_ack`, `snd_busy`, `cons_vld`, `req_out_vld` and `rsp_out_vld` are 0.
- R2: A send request seen in P_IDLE for a destination whose pending bit is set is refused. `snd_busy` pulses for one cycle in the next cycle, `snd_ack` stays 0, and the message is never delivered.
- R3: A send request seen in P_IDLE for a destination with no pending message is accepted. `snd_ack` pulses in the next cycle and the payload is stored locally. The consumer later receives exactly the payload that was stored at acceptance.
- R4: In the cycle after acceptance, the producer drives one request of kind 1 (flag) to the destination, unless the consumer side holds the request channel. It then returns to P_IDLE, and `snd_rdy` is 1 again one cycle later.
- R5: When a flag is set, the consumer clears it and, one cycle after it picks the flag, drives a request of kind 2 (read) to the source. Each accepted message is delivered exactly once.
- R6: The responder streams the WORDS payload words in index order. Word i is `snd_payload[i*DW +: DW]`, and the last marker is set on the final word. The consumer forwards the words on `cons_word`, with `cons_src` naming the source.
- R7: After the last word, the consumer drives a request of kind 3 (done). The producer then clears the pending bit for that pair, and a new send to the same destination is accepted.
- R8: When several flags are set at once, the consumer serves them in round-robin order. The search starts at the source id just after the one it served last, and wraps to 0 after N_TILES-1. After reset it starts at 0.
- R9: A done request for a pair with no pending message is dropped and sets `done_err`. The bit stays set until reset, and the pending bits of other pairs are not changed.
- R10: A pending message to one destination does not block sends to other destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | 1 | Send request from the local producer |
| snd_dst | input | IW | Destination tile of the send |
| snd_payload | input | WORDS*DW | Message payload, word 0 in the low bits |
| snd_rdy | output | 1 | Producer is in P_IDLE and can take a request |
| snd_ack | output | 1 | One-cycle pulse: the request was accepted |
| snd_busy | output | 1 | One-cycle pulse: the request was refused because the pair is pending |
| req_out_vld | output | 1 | Outgoing request valid |
| req_out_kind | output | 2 | Request kind: 1 flag, 2 read, 3 done |
| req_out_dst | output | IW | Tile that the request goes to |
| req_in_vld | input | N_TILES | Incoming request valid, one lane per source tile |
| req_in_kind | input | 2*N_TILES | Incoming request kind, 2 bits per lane |
| rsp_out_vld | output | 1 | Outgoing payload word valid |
| rsp_out_dst | output | IW | Tile that the payload word goes to |
| rsp_out_word | output | DW | Outgoing payload word |
| rsp_out_last | output | 1 | Final word of the burst |
| rsp_in_vld | input | N_TILES | Incoming payload word valid, one lane per source tile |
| rsp_in_word | input | N_TILES*DW | Incoming payload words, DW bits per lane |
| rsp_in_last | input | N_TILES | Final-word marker for each lane |
| cons_vld | output | 1 | Delivered word valid to the local sink |
| cons_src | output | IW | Source tile of the delivered word |
| cons_word | output | DW | Delivered word |
| cons_last | output | 1 | Final word of the delivered message |
| done_err | output | 1 | Sticky flag: a stray done request was received |

## Verification
The bench builds four tiles on a wired crossbar. A directed sequence runs first. It sends one message, repeats the send to the same pair at once, which shows the refusal apart from acceptance, and then sends to a second destination, which shows that pairs are independent. Two rounds of simultaneous flags then separate round-robin from fixed lowest-id priority: in each round, a fixed-priority design would serve a different source first. Four producers then send concurrently with random payloads and random destinations, which exercises contention for the request channel and overlapping bursts. Every delivered burst is compared word by word against the payload the bench stored at acceptance. A forged completion and a reset in the middle of activity cover the error flag and the cleared state.

// File: rtl/msg_pkg.sv
package msg_pkg;
    // Request channel kind codes
    localparam logic [1:0] KIND_NONE = 2'd0;
    localparam logic [1:0] KIND_FLAG = 2'd1;
    localparam logic [1:0] KIND_READ = 2'd2;
    localparam logic [1:0] KIND_DONE = 2'd3;

    typedef enum logic {P_IDLE, P_POST} prod_state_e;
    typedef enum logic [1:0] {C_IDLE, C_ASK, C_RECV, C_DONE} cons_state_e;
    typedef enum logic {R_IDLE, R_SEND} resp_state_e;
endpackage

// File: rtl/msg_prod.sv
module msg_prod
    import msg_pkg::*;
#(
    parameter int N_TILES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 16,
    localparam int IW     = (N_TILES > 1) ? $clog2(N_TILES) : 1,
    localparam int CW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snd_req,
    input  logic [IW-1:0]         snd_dst,
    input  logic [WORDS*DW-1:0]   snd_payload,
    output logic                  snd_rdy,
    output logic                  snd_ack,
    output logic                  snd_busy,
    output logic                  post_vld,
    output logic [IW-1:0]         post_dst,
    input  logic                  post_gnt,
    input  logic [N_TILES-1:0]    done_in,
    output logic                  done_err,
    input  logic [IW-1:0]         rd_sel,
    input  logic [CW-1:0]         rd_idx,
    output logic [DW-1:0]         rd_word
);
    prod_state_e state_q, state_d;
    logic [N_TILES-1:0] pend_q;
    logic [IW-1:0]      dst_q;
    logic [DW-1:0]      mem_q [N_TILES][WORDS];
    logic               take, refuse;

    assign take   = (state_q == P_IDLE) && snd_req && !pend_q[snd_dst];
    assign refuse = (state_q == P_IDLE) && snd_req &&  pend_q[snd_dst];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: if (take) state_d = P_POST;
            P_POST: if (post_gnt) state_d = P_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        snd_rdy  = (state_q == P_IDLE);
        post_vld = (state_q == P_POST);
        post_dst = dst_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            dst_q    <= '0;
            snd_ack  <= 1'b0;
            snd_busy <= 1'b0;
            done_err <= 1'b0;
        end else begin
            snd_ack  <= take;
            snd_busy <= refuse;
            if (take) dst_q <= snd_dst;
            pend_q <= (pend_q & ~done_in) |
                      (take ? (N_TILES'(1) << snd_dst) : '0);
            if ((done_in & ~pend_q) != '0) done_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TILES; t++)
                for (int w = 0; w < WORDS; w++)
                    mem_q[t][w] <= '0;
        end else if (take) begin
            for (int w = 0; w < WORDS; w++)
                mem_q[snd_dst][w] <= snd_payload[w*DW +: DW];
        end
    end

    assign rd_word = mem_q[rd_sel][rd_idx];

    a_r2_refuse_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_IDLE && snd_req && pend_q[snd_dst]) |=> (snd_busy && !snd_ack));
    a_r3_accept_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_IDLE && snd_req && !pend_q[snd_dst]) |=> (snd_ack && pend_q[$past(snd_dst)]));
    a_r4_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        snd_ack |-> post_vld);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |=> done_err);
endmodule

// File: rtl/msg_resp.sv
module msg_resp
    import msg_pkg::*;
#(
    parameter int N_TILES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 16,
    localparam int IW     = (N_TILES > 1) ? $clog2(N_TILES) : 1,
    localparam int CW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TILES-1:0] read_in,
    output logic               rsp_vld,
    output logic [IW-1:0]      rsp_dst,
    output logic [DW-1:0]      rsp_word,
    output logic               rsp_last,
    output logic [IW-1:0]      rd_sel,
    output logic [CW-1:0]      rd_idx,
    input  logic [DW-1:0]      rd_word
);
    resp_state_e state_q, state_d;
    logic [N_TILES-1:0] want_q;
    logic [IW-1:0]      sel_q, low;
    logic [CW-1:0]      idx_q;
    logic               any, at_end;

    always_comb begin
        any = 1'b0;
        low = '0;
        for (int k = N_TILES - 1; k >= 0; k--) begin
            if (want_q[k]) begin
                any = 1'b1;
                low = IW'(k);
            end
        end
    end

    assign at_end = (idx_q == CW'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (any) state_d = R_SEND;
            R_SEND: if (at_end) state_d = R_IDLE;
        endcase
    end

    always_comb begin
        rsp_vld  = (state_q == R_SEND);
        rsp_last = (state_q == R_SEND) && at_end;
        rsp_dst  = sel_q;
        rsp_word = rd_word;
        rd_sel   = sel_q;
        rd_idx   = idx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q <= '0;
            sel_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (state_q == R_IDLE && any) begin
                sel_q  <= low;
                idx_q  <= '0;
                want_q <= (want_q & ~(N_TILES'(1) << low)) | read_in;
            end else begin
                want_q <= want_q | read_in;
                if (state_q == R_SEND && !at_end) idx_q <= idx_q + 1'b1;
            end
        end
    end

    a_r6_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_last) |=> !rsp_vld);
    a_r6_burst_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_last) |=> (rsp_vld && $stable(rsp_dst)));
endmodule

// File: rtl/msg_cons.sv
module msg_cons
    import msg_pkg::*;
#(
    parameter int N_TILES = 4,
    parameter int DW      = 16,
    localparam int IW     = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_TILES-1:0]    flag_in,
    output logic                  rd_vld,
    output logic                  done_vld,
    output logic [IW-1:0]         cur_dst,
    input  logic [N_TILES-1:0]    rsp_in_vld,
    input  logic [N_TILES*DW-1:0] rsp_in_word,
    input  logic [N_TILES-1:0]    rsp_in_last,
    output logic                  cons_vld,
    output logic [IW-1:0]         cons_src,
    output logic [DW-1:0]         cons_word,
    output logic                  cons_last
);
    cons_state_e state_q, state_d;
    logic [N_TILES-1:0] sem_q;
    logic [IW-1:0]      last_q, cur_q, pick;
    logic               any, beat, beat_last;

    // Round-robin search starting after the last served source
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = last_q;
        idx  = 0;
        for (int k = 1; k <= N_TILES; k++) begin
            idx = (int'(last_q) + k) % N_TILES;
            if (!any && sem_q[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end

    assign beat      = (state_q == C_RECV) && rsp_in_vld[cur_q];
    assign beat_last = beat && rsp_in_last[cur_q];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: if (any) state_d = C_ASK;
            C_ASK:  state_d = C_RECV;
            C_RECV: if (beat_last) state_d = C_DONE;
            C_DONE: state_d = C_IDLE;
        endcase
    end

    always_comb begin
        rd_vld   = (state_q == C_ASK);
        done_vld = (state_q == C_DONE);
        cur_dst  = cur_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sem_q     <= '0;
            last_q    <= IW'(N_TILES - 1);
            cur_q     <= '0;
            cons_vld  <= 1'b0;
            cons_src  <= '0;
            cons_word <= '0;
            cons_last <= 1'b0;
        end else begin
            if (state_q == C_IDLE && any) begin
                sem_q  <= (sem_q & ~(N_TILES'(1) << pick)) | flag_in;
                cur_q  <= pick;
                last_q <= pick;
            end else begin
                sem_q <= sem_q | flag_in;
            end
            cons_vld  <= beat;
            cons_last <= beat_last;
            if (beat) begin
                cons_src  <= cur_q;
                cons_word <= rsp_in_word[cur_q*DW +: DW];
            end
        end
    end

    a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_ASK) |-> !sem_q[cur_q]);
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cons_last |-> cons_vld);
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        cons_last |-> (state_q == C_DONE));
endmodule

// File: rtl/msg_tile.sv
module msg_tile
    import msg_pkg::*;
#(
    parameter int N_TILES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 16,
    localparam int IW     = (N_TILES > 1) ? $clog2(N_TILES) : 1,
    localparam int CW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snd_req,
    input  logic [IW-1:0]         snd_dst,
    input  logic [WORDS*DW-1:0]   snd_payload,
    output logic                  snd_rdy,
    output logic                  snd_ack,
    output logic                  snd_busy,
    output logic                  req_out_vld,
    output logic [1:0]            req_out_kind,
    output logic [IW-1:0]         req_out_dst,
    input  logic [N_TILES-1:0]    req_in_vld,
    input  logic [2*N_TILES-1:0]  req_in_kind,
    output logic                  rsp_out_vld,
    output logic [IW-1:0]         rsp_out_dst,
    output logic [DW-1:0]         rsp_out_word,
    output logic                  rsp_out_last,
    input  logic [N_TILES-1:0]    rsp_in_vld,
    input  logic [N_TILES*DW-1:0] rsp_in_word,
    input  logic [N_TILES-1:0]    rsp_in_last,
    output logic                  cons_vld,
    output logic [IW-1:0]         cons_src,
    output logic [DW-1:0]         cons_word,
    output logic                  cons_last,
    output logic                  done_err
);
    logic [N_TILES-1:0] flag_in, read_in, done_in;
    logic               post_vld, post_gnt, rd_vld, done_vld;
    logic [IW-1:0]      post_dst, cur_dst, rd_sel;
    logic [CW-1:0]      rd_idx;
    logic [DW-1:0]      rd_word;

    for (genvar s = 0; s < N_TILES; s++) begin : g_lane
        assign flag_in[s] = req_in_vld[s] && (req_in_kind[2*s +: 2] == KIND_FLAG);
        assign read_in[s] = req_in_vld[s] && (req_in_kind[2*s +: 2] == KIND_READ);
        assign done_in[s] = req_in_vld[s] && (req_in_kind[2*s +: 2] == KIND_DONE);
    end

    // Consumer side owns the request channel first
    assign post_gnt = !(rd_vld || done_vld);

    always_comb begin
        req_out_vld  = 1'b0;
        req_out_kind = KIND_NONE;
        req_out_dst  = '0;
        if (rd_vld) begin
            req_out_vld = 1'b1; req_out_kind = KIND_READ; req_out_dst = cur_dst;
        end else if (done_vld) begin
            req_out_vld = 1'b1; req_out_kind = KIND_DONE; req_out_dst = cur_dst;
        end else if (post_vld) begin
            req_out_vld = 1'b1; req_out_kind = KIND_FLAG; req_out_dst = post_dst;
        end
    end

    msg_prod #(.N_TILES(N_TILES), .WORDS(WORDS), .DW(DW)) i_prod (
        .clk, .rst_n, .snd_req, .snd_dst, .snd_payload, .snd_rdy, .snd_ack, .snd_busy,
        .post_vld, .post_dst, .post_gnt, .done_in, .done_err,
        .rd_sel, .rd_idx, .rd_word
    );

    msg_resp #(.N_TILES(N_TILES), .WORDS(WORDS), .DW(DW)) i_resp (
        .clk, .rst_n, .read_in,
        .rsp_vld(rsp_out_vld), .rsp_dst(rsp_out_dst), .rsp_word(rsp_out_word),
        .rsp_last(rsp_out_last), .rd_sel, .rd_idx, .rd_word
    );

    msg_cons #(.N_TILES(N_TILES), .DW(DW)) i_cons (
        .clk, .rst_n, .flag_in, .rd_vld, .done_vld, .cur_dst,
        .rsp_in_vld, .rsp_in_word, .rsp_in_last,
        .cons_vld, .cons_src, .cons_word, .cons_last
    );

    a_r4_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_vld, done_vld}) <= 1);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!snd_ack && !snd_busy && !cons_vld && !done_err && snd_rdy));
endmodule

// File: tb/test_msg_tile.sv
`timescale 1ns/1ps
module test_msg_tile;
    localparam int NT = 4, W = 4, DW = 16, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NT-1:0] snd_req, snd_rdy, snd_ack, snd_busy, rq_vld, rs_vld, rs_last, c_vld, c_last, derr;
    logic [IW-1:0] snd_dst [NT];
    logic [IW-1:0] rq_dst [NT];
    logic [IW-1:0] rs_dst [NT];
    logic [IW-1:0] c_src [NT];
    logic [1:0]    rq_kind [NT];
    logic [W*DW-1:0] snd_pl [NT];
    logic [DW-1:0] rs_word [NT];
    logic [DW-1:0] c_word [NT];
    logic [NT-1:0]    li_vld [NT];
    logic [2*NT-1:0]  li_kind [NT];
    logic [NT-1:0]    lr_vld [NT];
    logic [NT-1:0]    lr_last [NT];
    logic [NT*DW-1:0] lr_word [NT];
    logic [NT-1:0]    inj [NT];

    // Ideal crossbar
    always_comb begin
        for (int d = 0; d < NT; d++) begin
            for (int s = 0; s < NT; s++) begin
                li_vld[d][s]        = (rq_vld[s] && rq_dst[s] == IW'(d)) || inj[d][s];
                li_kind[d][2*s +: 2] = inj[d][s] ? 2'd3 : rq_kind[s];
                lr_vld[d][s]        = rs_vld[s] && rs_dst[s] == IW'(d);
                lr_last[d][s]       = rs_last[s];
                lr_word[d][s*DW +: DW] = rs_word[s];
            end
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_tile
        msg_tile #(.N_TILES(NT), .WORDS(W), .DW(DW)) i_msg_tile (
            .clk, .rst_n,
            .snd_req(snd_req[t]), .snd_dst(snd_dst[t]), .snd_payload(snd_pl[t]),
            .snd_rdy(snd_rdy[t]), .snd_ack(snd_ack[t]), .snd_busy(snd_busy[t]),
            .req_out_vld(rq_vld[t]), .req_out_kind(rq_kind[t]), .req_out_dst(rq_dst[t]),
            .req_in_vld(li_vld[t]), .req_in_kind(li_kind[t]),
            .rsp_out_vld(rs_vld[t]), .rsp_out_dst(rs_dst[t]), .rsp_out_word(rs_word[t]),
            .rsp_out_last(rs_last[t]),
            .rsp_in_vld(lr_vld[t]), .rsp_in_word(lr_word[t]), .rsp_in_last(lr_last[t]),
            .cons_vld(c_vld[t]), .cons_src(c_src[t]), .cons_word(c_word[t]),
            .cons_last(c_last[t]), .done_err(derr[t])
        );
    end

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;
    bit          outst  [NT][NT];
    logic [W*DW-1:0] exp_pl [NT][NT];
    int          dl_cyc [NT][NT];
    logic [W*DW-1:0] rbuf [NT];
    int          rcnt [NT];
    int          nrcv [NT];
    int          hist [NT][1024];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Delivery monitor, sampled after outputs settle
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int d = 0; d < NT; d++) begin
                if (c_vld[d]) begin
                    rbuf[d][rcnt[d]*DW +: DW] = c_word[d];
                    if (c_last[d]) begin
                        int s;
                        s = int'(c_src[d]);
                        chk(rcnt[d] == W - 1, "R6", "burst length", rcnt[d] + 1, W);
                        chk(outst[s][d], "R5", "delivery without outstanding send", 0, 1);
                        chk(rbuf[d] == exp_pl[s][d], "R3", "payload", rbuf[d], exp_pl[s][d]);
                        outst[s][d] = 0;
                        dl_cyc[s][d] = cyc;
                        if (nrcv[d] < 1024) hist[d][nrcv[d]] = s;
                        nrcv[d]++;
                        rcnt[d] = 0;
                    end else begin
                        rcnt[d]++;
                    end
                end
            end
        end
    end

    // Returns 1 if a send was attempted; checks ack/busy against the model
    task automatic try_send(int s, int d, logic [W*DW-1:0] pl, string tag, output bit tried);
        bit exp_acc;
        tried = 0;
        @(negedge clk);
        while (!snd_rdy[s]) @(negedge clk);
        if (!outst[s][d] && cyc - dl_cyc[s][d] < 4) return;
        exp_acc = !outst[s][d];
        snd_req[s] = 1'b1; snd_dst[s] = IW'(d); snd_pl[s] = pl;
        @(negedge clk);
        snd_req[s] = 1'b0;
        tried = 1;
        chk(snd_ack[s] == exp_acc, tag, "snd_ack", snd_ack[s], exp_acc);
        chk(snd_busy[s] == !exp_acc, tag, "snd_busy", snd_busy[s], !exp_acc);
        if (exp_acc && snd_ack[s]) begin
            outst[s][d] = 1;
            exp_pl[s][d] = pl;
        end
    endtask

    task automatic rand_src(int s, int n);
        bit t;
        for (int i = 0; i < n; i++) begin
            int d;
            d = (s + 1 + int'($urandom % (NT - 1))) % NT;
            try_send(s, d, {$urandom, $urandom}, outst[s][d] ? "R2" : "R3", t);
            repeat ($urandom % 3) @(negedge clk);
        end
    endtask

    task automatic quiet(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit t;
        int base;
        void'($urandom(32'h5eed_0001));
        snd_req = '0;
        for (int i = 0; i < NT; i++) begin
            snd_dst[i] = '0; snd_pl[i] = '0; inj[i] = '0; rcnt[i] = 0; nrcv[i] = 0;
            for (int j = 0; j < NT; j++) begin outst[i][j] = 0; dl_cyc[i][j] = -100; end
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(snd_rdy == '1 && snd_ack == '0 && snd_busy == '0, "R1", "producer idle", {snd_rdy, snd_ack, snd_busy}, {4'hf, 8'h0});
        chk(c_vld == '0 && derr == '0 && rq_vld == '0 && rs_vld == '0, "R1", "quiet outputs", {c_vld, derr, rq_vld, rs_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(snd_rdy == '1 && derr == '0, "R1", "after release", {snd_rdy, derr}, 8'hf0);

        // Directed: accept, flag, refuse, independent pair
        try_send(0, 1, 64'h1111_2222_3333_4444, "R3", t);
        chk(rq_vld[0] && rq_kind[0] == 2'd1 && rq_dst[0] == 2'd1, "R4", "flag request", {rq_vld[0], rq_kind[0], rq_dst[0]}, {1'b1, 2'd1, 2'd1});
        try_send(0, 1, 64'hdead_beef_0000_0001, "R2", t);
        chk(rq_vld[1] && rq_kind[1] == 2'd2 && rq_dst[1] == 2'd0, "R5", "read request", {rq_vld[1], rq_kind[1], rq_dst[1]}, {1'b1, 2'd2, 2'd0});
        try_send(0, 2, 64'h0a0b_0c0d_0e0f_1011, "R10", t);
        quiet(30);
        chk(!outst[0][1] && !outst[0][2], "R5", "both delivered", {outst[0][1], outst[0][2]}, 0);
        try_send(0, 1, 64'h5555_6666_7777_8888, "R7", t);
        chk(t == 1, "R7", "resend attempted", t, 1);
        quiet(30);

        // R8 round robin: last served at tile 1 is 0 -> source 2 before 0
        base = nrcv[1];
        fork
            try_send(0, 1, 64'h0000_0000_0000_00a0, "R3", t);
            try_send(2, 1, 64'h0000_0000_0000_00a2, "R3", t);
        join
        quiet(40);
        chk(nrcv[1] == base + 2, "R8", "two deliveries", nrcv[1] - base, 2);
        chk(hist[1][base] == 2 && hist[1][base + 1] == 0, "R8", "order after 0", {hist[1][base], hist[1][base + 1]}, {32'd2, 32'd0});
        try_send(2, 1, 64'h0000_0000_0000_00b2, "R3", t);
        quiet(30);
        base = nrcv[1];
        fork
            try_send(0, 1, 64'h0000_0000_0000_00c0, "R3", t);
            try_send(3, 1, 64'h0000_0000_0000_00c3, "R3", t);
        join
        quiet(40);
        chk(hist[1][base] == 3 && hist[1][base + 1] == 0, "R8", "order after 2", {hist[1][base], hist[1][base + 1]}, {32'd3, 32'd0});

        // Random concurrent traffic
        fork
            rand_src(0, 80);
            rand_src(1, 80);
            rand_src(2, 80);
            rand_src(3, 80);
        join
        quiet(200);
        for (int s = 0; s < NT; s++)
            for (int d = 0; d < NT; d++)
                if (outst[s][d]) chk(0, "R5", "undelivered message", s * NT + d, -1);
        checks++;

        // R9 stray done into tile 3 from lane 0
        chk(derr == '0, "R9", "no error yet", derr, 0);
        @(negedge clk); inj[3][0] = 1'b1;
        @(negedge clk); inj[3][0] = 1'b0;
        chk(derr == 4'b1000, "R9", "error flag", derr, 4'b1000);
        quiet(5);
        chk(derr == 4'b1000, "R9", "sticky", derr, 4'b1000);
        try_send(3, 0, 64'h9999_aaaa_bbbb_cccc, "R9", t);
        quiet(30);
        chk(!outst[3][0], "R9", "pair still works", outst[3][0], 0);

        // R1 reset mid-activity
        try_send(1, 2, 64'h1234_5678_9abc_def0, "R3", t);
        rst_n = 1'b0;
        quiet(3);
        for (int i = 0; i < NT; i++) begin
            rcnt[i] = 0;
            for (int j = 0; j < NT; j++) outst[i][j] = 0;
        end
        chk(derr == '0 && snd_rdy == '1 && c_vld == '0, "R1", "reset clears", {derr, snd_rdy, c_vld}, {4'h0, 4'hf, 4'h0});
        rst_n = 1'b1;
        try_send(1, 2, 64'h0fed_cba9_8765_4321, "R1", t);
        quiet(30);
        chk(!outst[1][2], "R1", "clean delivery after reset", outst[1][2], 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule